// File: doc/BRIEF.md
# Card Window Decoder

This block sits between a host bus and a card socket and decides whether a host access falls into one of the socket's address windows. It holds up to five memory windows and two I/O windows. Each memory window is described in 4 KB pages: a first page, a last page and a page offset that moves the host page into card space. Each memory window also carries access attributes: data width, zero-wait, a wait code, write protect and an attribute-space select. Each I/O window is a 16-bit address range with its own width bit. A shared enable register switches each window on or off.

Configuration arrives through a single register write port, one 16-bit register per write. A lookup is a host request that states whether it targets memory or I/O, whether it is a write, and its address. One clock later the block reports the result kind, the winning window, the card address and the attributes. Card bus timing is left to the logic downstream.

The result kind is an enumerated code with four values: MISS (0), memory grant MEM (1), I/O grant IO (2) and write-protect fault PROT (3). A lookup moves from the request stage to the registered result in one step. No other state is held besides the configuration.

Top module: `win_decoder`

## Requirements
- R1: After reset every window is disabled, and every result output is zero, with kind MISS (0).
- R2: A memory request hits memory window i only when enable bit i is set and first page ≤ req_addr[23:12] ≤ last page. Both bounds are inclusive. A disabled or non-matching window never hits.
- R3: When several windows of the requested type match, the lowest-numbered one is reported on out_win.
- R4: On a memory grant the card address is {(page + offset) mod 2^14, req_addr[11:0]}, giving 26 bits. The page sum wraps.
- R5: Memory attributes come from the window registers. Width is first-page register bit 15, zero-wait is bit 14, the wait code is last-page register bits 15:14, and attribute space is offset register bit 14.
- R6: A write that hits a memory window whose offset register bit 15 is set gives kind PROT (3) with the window index and zero address and attributes. A read of the same window is granted.
- R7: An I/O request (req_io=1) compares req_addr[15:0] with the 16-bit I/O bounds, inclusive, and ignores req_addr[23:16] and all memory windows. A hit gives kind IO (2) with card address equal to req_addr[15:0] and width taken from I/O control bit j. A memory request ignores I/O windows.
- R8: The register index on cfg_sel is laid out as follows. For memory window i: 3i is the first page (bits 11:0), 3i+1 is the last page (bits 11:0), and 3i+2 is the offset (bits 13:0). I/O window j uses 15+2j for the first address and 16+2j for the last. Index 19 is I/O width (bit j), and index 20 is enable (bits 4:0 memory, bits 6:5 I/O).
- R9: The result of a request appears in the next cycle. A configuration write in the same cycle as a request affects only later requests.
- R10: When req_valid is low, the next cycle shows out_valid low and all result outputs zero, kind MISS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 5 | Register index |
| cfg_wdata | input | 16 | Register write data |
| req_valid | input | 1 | Lookup request present |
| req_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_write | input | 1 | Request is a write |
| req_addr | input | 24 | Host address |
| out_valid | output | 1 | Result belongs to a request |
| out_kind | output | 2 | 0 MISS, 1 MEM, 2 IO, 3 PROT |
| out_win | output | 3 | Winning window index |
| out_card_addr | output | 26 | Translated card address |
| out_wide | output | 1 | 16-bit data width |
| out_zws | output | 1 | Zero wait states |
| out_wait | output | 2 | Wait-state code |
| out_attr | output | 1 | Attribute space selected |

## Verification
A configuration write and a lookup can land in the same clock, and the lookup must then see the configuration as it stood before the write. The bench provokes this case by clearing the enable register in the same cycle as an I/O request that hits. It expects a grant for that request and a miss for the next one. Every cycle's result is compared against a behavioural model, and the model applies each write only after it has computed the expected result for that cycle.

// File: rtl/win_pkg.sv
package win_pkg;
    localparam int PAGE_W = 12;
    localparam int OFF_W  = 14;
    localparam int IOA_W  = 16;
    localparam int PG_SH  = 12;
    localparam int HADR_W = PAGE_W + PG_SH;
    localparam int CADR_W = OFF_W + PG_SH;

    typedef enum logic [1:0] {
        K_MISS = 2'd0,
        K_MEM  = 2'd1,
        K_IO   = 2'd2,
        K_PROT = 2'd3
    } kind_e;

    typedef struct packed {
        logic              wide;
        logic              zws;
        logic [1:0]        waitc;
        logic              wp;
        logic              attr;
        logic [PAGE_W-1:0] lo;
        logic [PAGE_W-1:0] hi;
        logic [OFF_W-1:0]  off;
    } mwin_t;

    typedef struct packed {
        logic             wide;
        logic [IOA_W-1:0] lo;
        logic [IOA_W-1:0] hi;
    } iowin_t;
endpackage

// File: rtl/win_regs.sv
module win_regs
    import win_pkg::*;
#(
    parameter int N_MEM = 5,
    parameter int N_IO  = 2,
    parameter int SEL_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [15:0]               cfg_wdata,
    output mwin_t  [N_MEM-1:0]        mw,
    output iowin_t [N_IO-1:0]         iw,
    output logic   [N_MEM-1:0]        mem_en,
    output logic   [N_IO-1:0]         io_en
);
    localparam int IO_BASE = 3 * N_MEM;
    localparam int CTL_IDX = IO_BASE + 2 * N_IO;
    localparam int EN_IDX  = CTL_IDX + 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw     <= '0;
            iw     <= '0;
            mem_en <= '0;
            io_en  <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < N_MEM; i++) begin
                if (cfg_sel == SEL_W'(3 * i)) begin
                    mw[i].wide <= cfg_wdata[15];
                    mw[i].zws  <= cfg_wdata[14];
                    mw[i].lo   <= cfg_wdata[PAGE_W-1:0];
                end
                if (cfg_sel == SEL_W'(3 * i + 1)) begin
                    mw[i].waitc <= cfg_wdata[15:14];
                    mw[i].hi    <= cfg_wdata[PAGE_W-1:0];
                end
                if (cfg_sel == SEL_W'(3 * i + 2)) begin
                    mw[i].wp   <= cfg_wdata[15];
                    mw[i].attr <= cfg_wdata[14];
                    mw[i].off  <= cfg_wdata[OFF_W-1:0];
                end
            end
            for (int j = 0; j < N_IO; j++) begin
                if (cfg_sel == SEL_W'(IO_BASE + 2 * j))
                    iw[j].lo <= cfg_wdata;
                if (cfg_sel == SEL_W'(IO_BASE + 2 * j + 1))
                    iw[j].hi <= cfg_wdata;
                if (cfg_sel == SEL_W'(CTL_IDX))
                    iw[j].wide <= cfg_wdata[j];
            end
            if (cfg_sel == SEL_W'(EN_IDX)) begin
                mem_en <= cfg_wdata[N_MEM-1:0];
                io_en  <= cfg_wdata[N_MEM+N_IO-1:N_MEM];
            end
        end
    end
endmodule

// File: rtl/win_match.sv
module win_match
    import win_pkg::*;
#(
    parameter int N_MEM = 5,
    parameter int N_IO  = 2
) (
    input  mwin_t  [N_MEM-1:0] mw,
    input  iowin_t [N_IO-1:0]  iw,
    input  logic   [N_MEM-1:0] mem_en,
    input  logic   [N_IO-1:0]  io_en,
    input  logic               req_io,
    input  logic [HADR_W-1:0]  req_addr,
    output logic [N_MEM-1:0]   mem_hits,
    output logic [N_IO-1:0]    io_hits
);
    logic [PAGE_W-1:0] page;
    logic [IOA_W-1:0]  ioa;

    assign page = req_addr[HADR_W-1:PG_SH];
    assign ioa  = req_addr[IOA_W-1:0];

    for (genvar i = 0; i < N_MEM; i++) begin : g_mem
        assign mem_hits[i] = mem_en[i] && !req_io &&
                             (page >= mw[i].lo) && (page <= mw[i].hi);
    end

    for (genvar j = 0; j < N_IO; j++) begin : g_io
        assign io_hits[j] = io_en[j] && req_io &&
                            (ioa >= iw[j].lo) && (ioa <= iw[j].hi);
    end
endmodule

// File: rtl/win_pick.sv
module win_pick #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  hits,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |hits;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/win_decoder.sv
module win_decoder
    import win_pkg::*;
#(
    parameter int N_MEM = 5,
    parameter int N_IO  = 2,
    localparam int WIN_W = $clog2((N_MEM > N_IO) ? N_MEM : N_IO),
    localparam int SEL_W = $clog2(3 * N_MEM + 2 * N_IO + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic              req_io,
    input  logic              req_write,
    input  logic [HADR_W-1:0] req_addr,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [WIN_W-1:0]  out_win,
    output logic [CADR_W-1:0] out_card_addr,
    output logic              out_wide,
    output logic              out_zws,
    output logic [1:0]        out_wait,
    output logic              out_attr
);
    mwin_t  [N_MEM-1:0] mw;
    iowin_t [N_IO-1:0]  iw;
    logic   [N_MEM-1:0] mem_en, mem_hits;
    logic   [N_IO-1:0]  io_en, io_hits;
    logic               m_found, i_found;
    logic [WIN_W-1:0]   m_idx, i_idx;

    win_regs #(.N_MEM(N_MEM), .N_IO(N_IO), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mw(mw), .iw(iw), .mem_en(mem_en), .io_en(io_en)
    );

    win_match #(.N_MEM(N_MEM), .N_IO(N_IO)) u_match (
        .mw(mw), .iw(iw), .mem_en(mem_en), .io_en(io_en), .req_io(req_io),
        .req_addr(req_addr), .mem_hits(mem_hits), .io_hits(io_hits)
    );

    win_pick #(.N(N_MEM), .IW(WIN_W)) u_pick_mem (
        .hits(mem_hits), .found(m_found), .idx(m_idx)
    );

    win_pick #(.N(N_IO), .IW(WIN_W)) u_pick_io (
        .hits(io_hits), .found(i_found), .idx(i_idx)
    );

    // next-result computation
    kind_e             n_kind;
    logic [WIN_W-1:0]  n_win;
    logic [CADR_W-1:0] n_addr;
    logic              n_wide, n_zws, n_attr;
    logic [1:0]        n_wait;
    mwin_t             sel_m;
    iowin_t            sel_i;
    logic [OFF_W-1:0]  card_page;

    assign sel_m     = mw[m_idx];
    assign sel_i     = iw[i_idx];
    assign card_page = OFF_W'(req_addr[HADR_W-1:PG_SH]) + sel_m.off;

    always_comb begin
        n_kind = K_MISS;
        n_win  = '0;
        n_addr = '0;
        n_wide = 1'b0;
        n_zws  = 1'b0;
        n_wait = 2'b00;
        n_attr = 1'b0;
        if (req_valid) begin
            unique case ({m_found, i_found})
                2'b10, 2'b11: begin
                    n_win = m_idx;
                    if (req_write && sel_m.wp) begin
                        n_kind = K_PROT;
                    end else begin
                        n_kind = K_MEM;
                        n_addr = {card_page, req_addr[PG_SH-1:0]};
                        n_wide = sel_m.wide;
                        n_zws  = sel_m.zws;
                        n_wait = sel_m.waitc;
                        n_attr = sel_m.attr;
                    end
                end
                2'b01: begin
                    n_kind = K_IO;
                    n_win  = i_idx;
                    n_addr = CADR_W'(req_addr[IOA_W-1:0]);
                    n_wide = sel_i.wide;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_kind      <= K_MISS;
            out_win       <= '0;
            out_card_addr <= '0;
            out_wide      <= 1'b0;
            out_zws       <= 1'b0;
            out_wait      <= 2'b00;
            out_attr      <= 1'b0;
        end else begin
            out_valid     <= req_valid;
            out_kind      <= n_kind;
            out_win       <= n_win;
            out_card_addr <= n_addr;
            out_wide      <= n_wide;
            out_zws       <= n_zws;
            out_wait      <= n_wait;
            out_attr      <= n_attr;
        end
    end
endmodule

// File: rtl/win_decoder_chk.sv
module win_decoder_chk
    import win_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_io,
    input logic              req_write,
    input logic [HADR_W-1:0] req_addr,
    input logic              out_valid,
    input logic [1:0]        out_kind,
    input logic [CADR_W-1:0] out_card_addr,
    input logic              out_wide,
    input logic              out_zws,
    input logic [1:0]        out_wait,
    input logic              out_attr
);
    // R9: result valid follows the request by one cycle
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R10: idle cycle yields an idle, empty result
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && out_kind == 2'd0 && out_card_addr == '0));

    // R6: a fault only follows a write
    p_fault_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_write |=> out_kind != 2'd3);

    // R7: I/O grants never follow a memory request, and carry no memory timing
    p_io_from_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_io |=> out_kind != 2'd2);
    p_io_no_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_kind == 2'd2 |-> (!out_zws && out_wait == 2'b00 && !out_attr));

    // R4: byte-in-page bits pass through on a memory grant
    p_page_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_io) |=>
        (out_kind != 2'd1 || out_card_addr[PG_SH-1:0] == $past(req_addr[PG_SH-1:0])));

    // R2: a miss carries no attributes
    p_miss_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_kind == 2'd0 |-> (!out_wide && !out_zws && out_wait == 2'b00 && !out_attr));
endmodule

bind win_decoder win_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_io(req_io),
    .req_write(req_write), .req_addr(req_addr), .out_valid(out_valid),
    .out_kind(out_kind), .out_card_addr(out_card_addr), .out_wide(out_wide),
    .out_zws(out_zws), .out_wait(out_wait), .out_attr(out_attr)
);

// File: tb/win_decoder_bench.sv
module win_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic        out_valid, out_wide, out_zws, out_attr;
    logic [1:0]  out_kind, out_wait;
    logic [2:0]  out_win;
    logic [25:0] out_card_addr;

    int checks = 0, fails = 0;
    bit done = 0;
    int m_reg[15];
    int io_reg[4];
    int ctl_reg = 0, en_reg = 0;

    always #5 clk = ~clk;

    win_decoder u_win_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_io(req_io),
        .req_write(req_write), .req_addr(req_addr), .out_valid(out_valid),
        .out_kind(out_kind), .out_win(out_win), .out_card_addr(out_card_addr),
        .out_wide(out_wide), .out_zws(out_zws), .out_wait(out_wait),
        .out_attr(out_attr)
    );

    function automatic logic [36:0] model(input logic v, input logic io,
                                          input logic wr, input int addr);
        int kind = 0, win = 0, card = 0, wide = 0, zws = 0, wt = 0, attr = 0;
        bit found = 0;
        if (v && !io) begin
            int page = (addr >> 12) & 'hFFF;
            for (int i = 0; i < 5; i++) begin
                if (!found && en_reg[i] && page >= (m_reg[3*i] & 'hFFF)
                    && page <= (m_reg[3*i+1] & 'hFFF)) begin
                    found = 1;
                    win = i;
                    if (wr && m_reg[3*i+2][15]) kind = 3;
                    else begin
                        kind = 1;
                        card = (((page + (m_reg[3*i+2] & 'h3FFF)) & 'h3FFF) << 12) | (addr & 'hFFF);
                        wide = m_reg[3*i][15];
                        zws  = m_reg[3*i][14];
                        wt   = (m_reg[3*i+1] >> 14) & 3;
                        attr = m_reg[3*i+2][14];
                    end
                end
            end
        end else if (v && io) begin
            int a = addr & 'hFFFF;
            for (int j = 0; j < 2; j++) begin
                if (!found && en_reg[5+j] && a >= io_reg[2*j] && a <= io_reg[2*j+1]) begin
                    found = 1;
                    kind = 2;
                    win = j;
                    card = a;
                    wide = ctl_reg[j];
                end
            end
        end
        return {v, kind[1:0], win[2:0], card[25:0], wide[0], zws[0], wt[1:0], attr[0]};
    endfunction

    task automatic model_write(input int sel, input int wd);
        if (sel < 15) m_reg[sel] = wd & 'hFFFF;
        else if (sel < 19) io_reg[sel-15] = wd & 'hFFFF;
        else if (sel == 19) ctl_reg = wd & 3;
        else if (sel == 20) en_reg = wd & 'h7F;
    endtask

    task automatic compare(input logic [36:0] exp, input string tag);
        logic [36:0] act;
        act = {out_valid, out_kind, out_win, out_card_addr, out_wide, out_zws, out_wait, out_attr};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input int sel, input int wd, input logic v,
                        input logic io, input logic wr, input int addr, input string tag);
        logic [36:0] exp;
        cfg_we = we; cfg_sel = sel[4:0]; cfg_wdata = wd[15:0];
        req_valid = v; req_io = io; req_write = wr; req_addr = addr[23:0];
        exp = model(v, io, wr, addr);
        if (we) model_write(sel, wd);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        compare(exp, tag);
    endtask

    task automatic cfg(input int sel, input int wd);
        step(1'b1, sel, wd, 1'b0, 1'b0, 1'b0, 0, "R10 idle during config");
    endtask

    task automatic look(input logic io, input logic wr, input int addr, input string tag);
        step(1'b0, 0, 0, 1'b1, io, wr, addr, tag);
    endtask

    initial begin
        foreach (m_reg[i]) m_reg[i] = 0;
        foreach (io_reg[i]) io_reg[i] = 0;
        repeat (3) @(negedge clk);
        compare(37'd0, "R1 reset outputs");
        rst_n = 1'b1;
        look(1'b0, 1'b0, 'h012ABC, "R1 all windows disabled");

        // memory window 0: pages 0x010..0x01F, wide+zws, wait 2, offset 0x3FF8 + attr
        cfg(0, 'hC010);
        cfg(1, 'h801F);
        cfg(2, 'h7FF8);
        look(1'b0, 1'b0, 'h012ABC, "R2 enable still clear");
        cfg(20, 'h01);
        look(1'b0, 1'b0, 'h012ABC, "R4 wrapped card page R5 attributes");
        look(1'b0, 1'b0, 'h00FFFF, "R2 below first page");
        look(1'b0, 1'b0, 'h010000, "R2 first page inclusive");
        look(1'b0, 1'b0, 'h01FFFF, "R2 last page inclusive");
        look(1'b0, 1'b0, 'h020000, "R2 above last page");

        // memory window 1: pages 0x015..0x030, offset 0x100, write protected
        cfg(3, 'h0015);
        cfg(4, 'h4030);
        cfg(5, 'h8100);
        cfg(20, 'h03);
        look(1'b0, 1'b0, 'h018123, "R3 lowest window wins");
        look(1'b0, 1'b0, 'h025456, "R4 offset add on window 1");
        look(1'b0, 1'b1, 'h025456, "R6 protected write faults");
        look(1'b0, 1'b1, 'h012000, "R6 write to unprotected window");
        cfg(20, 'h02);
        look(1'b0, 1'b0, 'h018123, "R3 window 1 once window 0 off");

        // window 4 at page 0x100 via its register indices
        cfg(12, 'h0100);
        cfg(13, 'hC100);
        cfg(14, 'h0000);
        cfg(20, 'h12);
        look(1'b0, 1'b0, 'h100777, "R8 window 4 mapping");

        // I/O windows
        cfg(15, 'h0300);
        cfg(16, 'h030F);
        cfg(17, 'h0308);
        cfg(18, 'h03FF);
        cfg(19, 'h0002);
        cfg(20, 'h62);
        look(1'b1, 1'b0, 'h000305, "R7 io window 0");
        look(1'b1, 1'b1, 'h00030A, "R7 R3 io overlap priority");
        look(1'b1, 1'b0, 'h000310, "R7 io window 1 wide");
        look(1'b1, 1'b0, 'h000400, "R7 io miss");
        look(1'b1, 1'b0, 'h018305, "R7 io ignores upper bits and memory windows");
        look(1'b0, 1'b0, 'h000305, "R7 memory request ignores io windows");

        // same-cycle configuration write and lookup
        step(1'b1, 20, 'h02, 1'b1, 1'b1, 1'b0, 'h000305, "R9 lookup sees old enables");
        look(1'b1, 1'b0, 'h000305, "R9 next lookup sees new enables");

        step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 'h025000, "R10 no request gives empty result");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule